// File: doc/BRIEF.md
# Test Pattern Injection Controller

This block sits in the trigger data path of a multi-link receiver and can replace live front-end link data with stored test patterns. Each link has its own pattern memory, which the host fills over a simple write port. Live data passes to the output unchanged, with no added latency, until injection is both armed and fired.

Injection takes two steps. First the host sets a level-sensitive mode bit. Setting this bit alone changes nothing, and live data keeps flowing. Then a one-cycle test-enable pulse, decoded from the timing broadcast by logic outside this block, starts playback. The stored words then play out once, one address per bunch-crossing clock, on all links at the same time. After the last word the output returns to live data.

The memories keep their contents, so the same sequence can be fired again. The bunch-crossing number present when the trigger was accepted is held in a register that the host can read. Clearing the mode bit during playback stops it.

Top module: `tpinj_top`

## Requirements
- R1: Each link has its own pattern memory of PAT_DEPTH words, so different links can hold different data. The output bus carries link i at bits [i*DATA_W +: DATA_W], and the live input bus uses the same layout.
- R2: When host_wr_en is high at a rising clock edge, host_wr_data is stored at word host_wr_addr of the memory for link host_wr_link. A word rewritten between runs appears in the next playback.
- R3: Neither a high pattern_mode on its own nor a test_enable pulse while pattern_mode is low starts playback. In both cases out_data equals live_data and playing stays low.
- R4: A test_enable pulse sampled at a rising edge, while pattern_mode is high and no playback is running, starts playback. In the n-th cycle after that edge (n counted from 0), out_data carries word n of every link's memory.
- R5: Playback lasts exactly PAT_DEPTH cycles, with playing high for exactly those cycles. After that, out_data equals live_data again.
- R6: Playback does not alter the memories. A later trigger replays the same words.
- R7: last_trig_bx takes the value of bx_num at the edge where a trigger is accepted, and holds it until the next accepted trigger.
- R8: A test_enable pulse during playback is ignored. The word sequence does not restart, and last_trig_bx does not change.
- R9: If pattern_mode is low at a rising edge during playback, playback stops at that edge, and out_data equals live_data from the next cycle on.
- R10: After reset, playing is low, last_trig_bx is zero and out_data equals live_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the pattern memories |
| host_wr_link | input | LINK_W | Link whose memory is written |
| host_wr_addr | input | ADDR_W | Word address of the write |
| host_wr_data | input | DATA_W | Word to store |
| pattern_mode | input | 1 | Host arming bit, level sensitive |
| test_enable | input | 1 | One-cycle trigger pulse from the timing broadcast |
| bx_num | input | BX_W | Current bunch-crossing number |
| live_data | input | NUM_LINKS*DATA_W | Live front-end data, all links |
| out_data | output | NUM_LINKS*DATA_W | Live or pattern data, all links |
| playing | output | 1 | High while playback runs |
| last_trig_bx | output | BX_W | Bunch-crossing number of the last accepted trigger |

## Verification
The bench goes after the arming gate: a pulse with the mode bit low, and the mode bit high with no pulse. A design that gated only on the pulse would inject in the first case. The bench counts the playback length cycle by cycle: an off-by-one address wrap would show one word too many or too few, or would lose the last stored word. It also fires a second pulse in the middle of playback and clears the mode bit in the middle of playback. A design that restarted on the second pulse would replay word 0 and overwrite the latched bunch-crossing number, and one that ignored the abort would keep showing pattern words. Finally, the bench replays after a single-word rewrite, which catches a design that loses or scrambles memory contents between runs.

// File: rtl/tpinj_pkg.sv
package tpinj_pkg;

  // Next playback address, wrapping at the memory depth.
  function automatic int unsigned step_addr(input int unsigned cur, input int unsigned depth);
    return (cur + 1 == depth) ? 0 : cur + 1;
  endfunction

  // True when the address is the final word of the memory.
  function automatic logic is_last(input int unsigned cur, input int unsigned depth);
    return cur == depth - 1;
  endfunction

endpackage

// File: rtl/tpinj_ram.sv
module tpinj_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tpinj_seq.sv
module tpinj_seq #(
  parameter int DEPTH = 128,
  parameter int BX_W  = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              te_i,
  input  logic [BX_W-1:0]   bx_i,
  output logic              playing_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BX_W-1:0]   trig_bx_o
);

  logic              playing_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BX_W-1:0]   trig_bx_q;

  // Named internal events
  wire start_evt = mode_i && te_i && !playing_q;
  wire abort_evt = playing_q && !mode_i;
  wire end_evt   = playing_q && mode_i && tpinj_pkg::is_last(int'(addr_q), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      playing_q <= 1'b0;
      addr_q    <= '0;
      trig_bx_q <= '0;
    end else if (start_evt) begin
      playing_q <= 1'b1;
      addr_q    <= '0;
      trig_bx_q <= bx_i;
    end else if (abort_evt || end_evt) begin
      playing_q <= 1'b0;
      addr_q    <= '0;
    end else if (playing_q) begin
      addr_q <= ADDR_W'(tpinj_pkg::step_addr(int'(addr_q), DEPTH));
    end
  end

  assign playing_o = playing_q;
  assign addr_o    = addr_q;
  assign trig_bx_o = trig_bx_q;

  // R3 / R9: with the mode bit low at an edge, nothing plays afterwards
  a_r9_mode_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> !playing_q);

  // R4: an accepted trigger starts at word 0
  a_r4_start_word0: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (playing_q && addr_q == '0));

  // R5: the final word ends playback
  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !playing_q);

  // R8: a running playback advances by one word even when a pulse arrives
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (playing_q && mode_i && !end_evt) |=> (playing_q && addr_q == $past(addr_q) + ADDR_W'(1)));

  // R7 / R8: the time stamp changes only on an accepted trigger
  a_r7_bx_latch: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (trig_bx_q == $past(bx_i)));

  a_r8_bx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    playing_q |=> $stable(trig_bx_q));

endmodule

// File: rtl/tpinj_top.sv
module tpinj_top #(
  parameter int NUM_LINKS = 4,
  parameter int DATA_W    = 8,
  parameter int PAT_DEPTH = 128,
  parameter int BX_W      = 12,
  localparam int ADDR_W   = $clog2(PAT_DEPTH),
  localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int BUS_W    = NUM_LINKS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [LINK_W-1:0] host_wr_link,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              pattern_mode,
  input  logic              test_enable,
  input  logic [BX_W-1:0]   bx_num,
  input  logic [BUS_W-1:0]  live_data,
  output logic [BUS_W-1:0]  out_data,
  output logic              playing,
  output logic [BX_W-1:0]   last_trig_bx
);

  logic [ADDR_W-1:0] rd_addr;

  tpinj_seq #(.DEPTH(PAT_DEPTH), .BX_W(BX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (pattern_mode),
    .te_i      (test_enable),
    .bx_i      (bx_num),
    .playing_o (playing),
    .addr_o    (rd_addr),
    .trig_bx_o (last_trig_bx)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    logic [DATA_W-1:0] pat_word;
    wire sel_wr = host_wr_en && (host_wr_link == LINK_W'(i));

    tpinj_ram #(.DATA_W(DATA_W), .DEPTH(PAT_DEPTH)) u_ram (
      .clk     (clk),
      .wr_en   (sel_wr),
      .wr_addr (host_wr_addr),
      .wr_data (host_wr_data),
      .rd_addr (rd_addr),
      .rd_data (pat_word)
    );

    assign out_data[i*DATA_W +: DATA_W] = playing ? pat_word : live_data[i*DATA_W +: DATA_W];

    // R3: when idle the link passes live data through
    always_comb begin
      if (rst_n && !playing)
        a_r3_live_pass: assert (out_data[i*DATA_W +: DATA_W] == live_data[i*DATA_W +: DATA_W]);
    end
  end

endmodule

// File: tb/sim_tpinj_top.sv
module sim_tpinj_top;
  localparam int NL = 4;
  localparam int DW = 8;
  localparam int PD = 128;
  localparam int BW = 12;
  localparam int AW = $clog2(PD);
  localparam int LW = $clog2(NL);
  localparam int RUN = PD + 6;

  // Scenario table: mode, trigger at cycle 2, extra pulse cycle (0 none), abort cycle (0 none)
  localparam int NSC = 5;
  localparam int SCN [NSC][4] = '{
    '{0, 1, 0,  0},   // R3 pulse without mode
    '{1, 0, 0,  0},   // R3 mode without pulse
    '{1, 1, 0,  0},   // R4 R5 full playback
    '{1, 1, 40, 0},   // R6 R8 replay with mid-run pulse
    '{1, 1, 0,  50}   // R9 abort
  };

  logic clk = 0, rst_n = 0;
  logic host_wr_en = 0;
  logic [LW-1:0] host_wr_link = '0;
  logic [AW-1:0] host_wr_addr = '0;
  logic [DW-1:0] host_wr_data = '0;
  logic pattern_mode = 0, test_enable = 0;
  logic [BW-1:0] bx_num = '0;
  logic [NL*DW-1:0] live_data = '0;
  logic [NL*DW-1:0] out_data;
  logic playing;
  logic [BW-1:0] last_trig_bx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] exp_mem [NL][PD];
  bit exp_play = 0;
  int exp_addr = 0;
  logic [BW-1:0] exp_bx = '0;
  int cyc = 0;

  always #10 clk = ~clk;

  tpinj_top #(.NUM_LINKS(NL), .DATA_W(DW), .PAT_DEPTH(PD), .BX_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_link(host_wr_link),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data), .pattern_mode(pattern_mode),
    .test_enable(test_enable), .bx_num(bx_num), .live_data(live_data),
    .out_data(out_data), .playing(playing), .last_trig_bx(last_trig_bx));

  function automatic logic [DW-1:0] pat(int l, int a);
    return DW'(l * 53 + a * 7 + 11);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic host_write(int l, int a, logic [DW-1:0] d);
    @(negedge clk);
    host_wr_en = 1; host_wr_link = LW'(l); host_wr_addr = AW'(a); host_wr_data = d;
    exp_mem[l][a] = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  // One cycle: drive inputs, check outputs, then advance the bench model
  task automatic cycle_step(bit mode, bit te, string req);
    logic [NL*DW-1:0] exp_out;
    @(negedge clk);
    cyc++;
    bx_num = BW'(cyc * 3);
    for (int l = 0; l < NL; l++) live_data[l*DW +: DW] = DW'(cyc * 3 + l + 200);
    pattern_mode = mode;
    test_enable = te;
    #1;
    for (int l = 0; l < NL; l++)
      exp_out[l*DW +: DW] = exp_play ? exp_mem[l][exp_addr] : live_data[l*DW +: DW];
    check({req, " R1 out_data"}, 64'(out_data), 64'(exp_out));
    check({req, " playing"}, 64'(playing), 64'(exp_play));
    if (mode && te && !exp_play) begin
      exp_play = 1; exp_addr = 0; exp_bx = bx_num;
    end else if (exp_play) begin
      if (!mode || exp_addr == PD - 1) begin exp_play = 0; exp_addr = 0; end
      else exp_addr++;
    end
  endtask

  task automatic run_scn(int m, int trig, int extra, int abrt, string req);
    for (int c = 0; c < RUN; c++) begin
      bit md = (m != 0) && !(abrt != 0 && c >= abrt);
      bit te = (trig != 0 && c == 2) || (extra != 0 && c == extra);
      cycle_step(md, te, req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int l = 0; l < NL; l++) live_data[l*DW +: DW] = DW'(l + 90);
    #1;
    check("R10 playing", 64'(playing), 64'(0));
    check("R10 last_trig_bx", 64'(last_trig_bx), 64'(0));
    check("R10 out_data", 64'(out_data), 64'(live_data));

    for (int l = 0; l < NL; l++)
      for (int a = 0; a < PD; a++) host_write(l, a, pat(l, a));

    for (int s = 0; s < NSC; s++) begin
      string req;
      case (s)
        0, 1: req = "R3";
        2: req = "R5";
        3: req = "R8";
        default: req = "R9";
      endcase
      run_scn(SCN[s][0], SCN[s][1], SCN[s][2], SCN[s][3], req);
      check({req, " R7 last_trig_bx"}, 64'(last_trig_bx), 64'(exp_bx));
    end

    // R2: rewrite one word on one link and at the last address, then replay
    host_write(2, 5, 8'h5A);
    host_write(NL - 1, PD - 1, 8'hC3);
    run_scn(1, 1, 0, 0, "R2");
    check("R6 R7 last_trig_bx", 64'(last_trig_bx), 64'(exp_bx));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule